// File: doc/BRIEF.md
# Port-Aware Low-Power Mode Controller

This block decides when a single-port serial-bus node stops its clock generators and analog references, and when it brings them back. Sleep is entered on its own when two things hold at once: the host is in a deep power state (D2 or D3), and the cable port is doing no useful work. While asleep, the block keeps only the line-sense references that the port's current state needs, so a meaningful cable event can still be seen. It drops to a deeper level when no such event could matter.

Leaving sleep happens in two ways. The host can set its low-power-service request, or the port can report an event that needs the node awake. The controller then re-enables the clocks and waits a programmable lock interval, which stands in for the PLL lock time. After that interval it raises clock-ready. A register access attempted before clock-ready is answered with a failure pulse instead of an acknowledge.

Top module: `lpm_ctrl`

## Requirements
- R1: While reset is held, and just after it, the controller is in the waking state: `clk_gen_en`=1, `clk_ready`=0, `ultra_sleep`=0.
- R2: From the active state, the controller goes to sleep only when all of these hold: `host_pstate` is 2 or 3 (encoding 0=D0, 1=D1, 2=D2, 3=D3), the port is inactive (`port_conn`=0, `port_dis`=1 or `port_susp`=1), `lps_req`=0, and no waking event is present.
- R3: `clk_gen_en` is 0 in both sleep levels and 1 in the waking and active states.
- R4: While asleep, `ref_conn_en` = (!`port_dis` | `port_susp`) and `ref_bias_en` = `port_susp`. While awake, both are 1.
- R5: The deep level (`ultra_sleep`=1) is used exactly when the controller is asleep, the port is disconnected or disabled, and `port_irq_en`=0. Otherwise the sleep is shallow.
- R6: `lps_req`=1 while asleep sets `clk_gen_en` on the next clock edge.
- R7: While asleep, a one-cycle pulse wakes the node on the next edge in these cases: `ev_bias` or `ev_disc` while the port is suspended, or `ev_conn` while the port is not disabled. Any other pulse leaves the sleep level unchanged.
- R8: `clk_ready` rises exactly `lock_dly`+1 clock edges after the edge on which waking starts. It is never 1 while `clk_gen_en` is 0.
- R9: A `reg_req` pulse gives a one-cycle `reg_ack` one edge later when `clk_ready` is 1. When `clk_ready` is 0 it gives a one-cycle `acc_fail` instead. Exactly one of the two responds.
- R10: `port_conn`, `port_dis` and `port_susp` pass through a two-flop synchronizer, so a change takes part in decisions on the third edge after it. `host_pstate`, `lps_req`, `port_irq_en`, the event pulses and `lock_dly` are synchronous and used directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_pstate | input | 2 | Host power state, 0..3 = D0..D3 |
| port_conn | input | 1 | Port connected (asynchronous) |
| port_dis | input | 1 | Port disabled (asynchronous) |
| port_susp | input | 1 | Port suspended (asynchronous) |
| port_irq_en | input | 1 | Port interrupt enable |
| lps_req | input | 1 | Host low-power-service request bit |
| ev_bias | input | 1 | Incoming bias detected, one-cycle pulse |
| ev_disc | input | 1 | Disconnection detected, one-cycle pulse |
| ev_conn | input | 1 | New connection detected, one-cycle pulse |
| lock_dly | input | DLY_W | Clock lock wait, in cycles minus one |
| reg_req | input | 1 | Register access attempt, one-cycle pulse |
| clk_gen_en | output | 1 | Clock generator enable |
| ref_conn_en | output | 1 | Connection/disconnection sense reference enable |
| ref_bias_en | output | 1 | Incoming-bias sense reference enable |
| ultra_sleep | output | 1 | Deepest sleep level active |
| clk_ready | output | 1 | Clocks locked and usable |
| reg_ack | output | 1 | Register access accepted |
| acc_fail | output | 1 | Register access refused, clocks not ready |

## Verification
The properties assume that `lock_dly` is held steady during a wake-up, and that `reg_req` and the event inputs are single-cycle pulses aligned to the clock. They are disabled until the internal synchronized reset has released.

The stimulus changes the port status only while the controller is awake, or while it is being sent to sleep. It then waits more cycles than the synchronizer latency before it checks anything. Events and register requests are always driven for exactly one cycle.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [1:0] {
    ST_ACTIVE = 2'd0,
    ST_LOWPWR = 2'd1,
    ST_DEEP   = 2'd2,
    ST_WAKE   = 2'd3
  } lpm_state_e;

  typedef struct packed {
    logic conn;
    logic dis;
    logic susp;
  } port_stat_t;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/lpm_sync.sv
module lpm_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q    <= 1'b0;
        q_sync[i] <= 1'b0;
      end else begin
        meta_q    <= d_async[i];
        q_sync[i] <= meta_q;
      end
    end
  end
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_pstate,
  input  port_stat_t       stat,
  input  logic             port_irq_en,
  input  logic             lps_req,
  input  logic             ev_bias,
  input  logic             ev_disc,
  input  logic             ev_conn,
  input  logic [DLY_W-1:0] lock_dly,
  output lpm_state_e       state
);
  lpm_state_e       state_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             inactive, deep_ok, sleep_ok, wake_ev, lock_done;

  always_comb begin
    inactive  = !stat.conn || stat.dis || stat.susp;
    deep_ok   = (!stat.conn || stat.dis) && !port_irq_en;
    wake_ev   = lps_req
             || (stat.susp && (ev_bias || ev_disc))
             || (!stat.dis && ev_conn);
    sleep_ok  = host_pstate[1] && inactive && !wake_ev;
    lock_done = (cnt_q == lock_dly);
  end

  always_comb begin
    state_d = state;
    unique case (state)
      ST_ACTIVE: if (sleep_ok) state_d = deep_ok ? ST_DEEP : ST_LOWPWR;
      ST_LOWPWR,
      ST_DEEP:   if (wake_ev) state_d = ST_WAKE;
                 else state_d = deep_ok ? ST_DEEP : ST_LOWPWR;
      ST_WAKE:   if (lock_done) state_d = ST_ACTIVE;
      default:   state_d = ST_WAKE;
    endcase
  end

  always_comb begin
    cnt_en = (state == ST_WAKE) || (cnt_q != '0);
    cnt_d  = (state == ST_WAKE && !lock_done) ? cnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_WAKE;
    end else begin
      state <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       host_pstate,
  input  logic             port_conn,
  input  logic             port_dis,
  input  logic             port_susp,
  input  logic             port_irq_en,
  input  logic             lps_req,
  input  logic             ev_bias,
  input  logic             ev_disc,
  input  logic             ev_conn,
  input  logic [DLY_W-1:0] lock_dly,
  input  logic             reg_req,
  output logic             clk_gen_en,
  output logic             ref_conn_en,
  output logic             ref_bias_en,
  output logic             ultra_sleep,
  output logic             clk_ready,
  output logic             reg_ack,
  output logic             acc_fail
);
  localparam int STAT_W = $bits(port_stat_t);

  logic       rst_int_n;
  port_stat_t stat_s;
  lpm_state_e state;
  logic       ack_d, fail_d;

  lpm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lpm_sync #(.W(STAT_W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .d_async ({port_conn, port_dis, port_susp}),
    .q_sync  (stat_s)
  );

  lpm_fsm #(.DLY_W(DLY_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .host_pstate (host_pstate),
    .stat        (stat_s),
    .port_irq_en (port_irq_en),
    .lps_req     (lps_req),
    .ev_bias     (ev_bias),
    .ev_disc     (ev_disc),
    .ev_conn     (ev_conn),
    .lock_dly    (lock_dly),
    .state       (state)
  );

  always_comb begin
    clk_gen_en  = (state == ST_ACTIVE) || (state == ST_WAKE);
    clk_ready   = (state == ST_ACTIVE);
    ultra_sleep = (state == ST_DEEP);
    ref_conn_en = clk_gen_en || !stat_s.dis || stat_s.susp;
    ref_bias_en = clk_gen_en || stat_s.susp;
    ack_d       = reg_req && clk_ready;
    fail_d      = reg_req && !clk_ready;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      reg_ack  <= 1'b0;
      acc_fail <= 1'b0;
    end else begin
      reg_ack  <= ack_d;
      acc_fail <= fail_d;
    end
  end
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int DLY_W = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] host_pstate,
  input logic       lps_req,
  input logic       reg_req,
  input logic       clk_gen_en,
  input logic       ultra_sleep,
  input logic       clk_ready,
  input logic       reg_ack,
  input logic       acc_fail
);
  localparam int CW = DLY_W + 2;
  localparam logic [CW-1:0] WAKE_MAX = CW'(1) << DLY_W;

  logic [CW-1:0] wake_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wake_cnt <= '0;
    end else if (clk_gen_en && !clk_ready) begin
      wake_cnt <= wake_cnt + 1'b1;
    end else begin
      wake_cnt <= '0;
    end
  end

  // R3
  deep_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ultra_sleep |-> !clk_gen_en);

  // R6
  lps_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lps_req && !clk_gen_en) |=> clk_gen_en);

  // R8
  ready_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_ready |-> clk_gen_en);

  // R8
  wake_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_cnt <= WAKE_MAX);

  // R2
  entry_pstate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(clk_gen_en) |-> $past(host_pstate[1]) && !$past(lps_req));

  // R9
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |=> (reg_ack != acc_fail));

  // R9
  fail_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !clk_ready) |=> acc_fail);
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_int_n),
  .host_pstate (host_pstate),
  .lps_req     (lps_req),
  .reg_req     (reg_req),
  .clk_gen_en  (clk_gen_en),
  .ultra_sleep (ultra_sleep),
  .clk_ready   (clk_ready),
  .reg_ack     (reg_ack),
  .acc_fail    (acc_fail)
);

// File: tb/lpm_ctrl_bench.sv
module lpm_ctrl_bench;
  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       host_pstate;
  logic             port_conn, port_dis, port_susp, port_irq_en;
  logic             lps_req, ev_bias, ev_disc, ev_conn, reg_req;
  logic [DLY_W-1:0] lock_dly;
  logic             clk_gen_en, ref_conn_en, ref_bias_en, ultra_sleep;
  logic             clk_ready, reg_ack, acc_fail;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.DLY_W(DLY_W)) u_lpm_ctrl (
    .clk(clk), .rst_n(rst_n), .host_pstate(host_pstate),
    .port_conn(port_conn), .port_dis(port_dis), .port_susp(port_susp),
    .port_irq_en(port_irq_en), .lps_req(lps_req),
    .ev_bias(ev_bias), .ev_disc(ev_disc), .ev_conn(ev_conn),
    .lock_dly(lock_dly), .reg_req(reg_req),
    .clk_gen_en(clk_gen_en), .ref_conn_en(ref_conn_en),
    .ref_bias_en(ref_bias_en), .ultra_sleep(ultra_sleep),
    .clk_ready(clk_ready), .reg_ack(reg_ack), .acc_fail(acc_fail)
  );

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bring controller to active via the service request, then release it
  task automatic go_active();
    lps_req = 1'b1;
    step(int'(lock_dly) + 4);
    check("R6", "clk_ready after request", clk_ready, 1'b1);
    lps_req = 1'b0;
  endtask

  task automatic pulse_ev(input int which);
    ev_bias = (which == 0);
    ev_disc = (which == 1);
    ev_conn = (which == 2);
    step(1);
    ev_bias = 1'b0; ev_disc = 1'b0; ev_conn = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; host_pstate = 2'd3; port_conn = 1'b0; port_dis = 1'b0;
    port_susp = 1'b0; port_irq_en = 1'b0; lps_req = 1'b1;
    ev_bias = 1'b0; ev_disc = 1'b0; ev_conn = 1'b0; reg_req = 1'b0;
    lock_dly = 8'd3;
    step(3);
    check("R1", "clk_gen_en in reset", clk_gen_en, 1'b1);
    check("R1", "clk_ready in reset", clk_ready, 1'b0);
    check("R1", "ultra_sleep in reset", ultra_sleep, 1'b0);
    rst_n = 1'b1;
    step(1);
    check("R1", "clk_ready after release", clk_ready, 1'b0);
    step(10);
    check("R1", "active after reset wake", clk_ready, 1'b1);

    // sweep every host state and port configuration
    for (int p = 0; p < 4; p++) begin
      for (int cfg = 0; cfg < 16; cfg++) begin
        logic c, d, s, ie, slp, deep, wk;
        c = cfg[0]; d = cfg[1]; s = cfg[2]; ie = cfg[3];
        host_pstate = 2'(p);
        port_conn = c; port_dis = d; port_susp = s; port_irq_en = ie;
        go_active();
        step(4);  // R10: synchronizer plus decision edge
        slp  = (p >= 2) && (!c || d || s);
        deep = slp && (!c || d) && !ie;
        check("R2", "sleep entry", !clk_gen_en, slp);
        check("R3", "clk_gen_en", clk_gen_en, !slp);
        check("R5", "ultra_sleep", ultra_sleep, deep);
        check("R4", "ref_conn_en", ref_conn_en, !slp || !d || s);
        check("R4", "ref_bias_en", ref_bias_en, !slp || s);
        reg_req = 1'b1; step(1); reg_req = 1'b0;
        check("R9", "acc_fail", acc_fail, slp);
        check("R9", "reg_ack", reg_ack, !slp);
        if (slp) begin
          for (int e = 0; e < 3; e++) begin
            pulse_ev(e);
            wk = (e == 2) ? !d : s;
            check("R7", "event wake", clk_gen_en, wk);
            if (!wk) check("R7", "level kept", ultra_sleep, deep);
            go_active();
            step(4);
          end
        end
      end
    end

    // wake delay sweep on a deep-sleeping, disconnected port
    host_pstate = 2'd3; port_conn = 1'b0; port_dis = 1'b0;
    port_susp = 1'b0; port_irq_en = 1'b0;
    for (int dly = 0; dly < 7; dly++) begin
      lock_dly = 8'(dly);
      go_active();
      step(4);
      check("R5", "deep before wake", ultra_sleep, 1'b1);
      lps_req = 1'b1; step(1);
      check("R6", "clocks on", clk_gen_en, 1'b1);
      check("R8", "not ready at wake start", clk_ready, 1'b0);
      if (dly > 0) begin
        step(dly);
        check("R8", "not ready one edge early", clk_ready, 1'b0);
        reg_req = 1'b1; step(1); reg_req = 1'b0;
        check("R9", "fail while waking", acc_fail, 1'b1);
        check("R8", "ready on time", clk_ready, 1'b1);
      end else begin
        step(1);
        check("R8", "ready on time", clk_ready, 1'b1);
      end
      reg_req = 1'b1; step(1); reg_req = 1'b0;
      check("R9", "ack when ready", reg_ack, 1'b1);
      lps_req = 1'b0;
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule